// File: doc/BRIEF.md
# Three-Wire Register-Map Slave

This block lets a host read and write a bank of 32 sixteen-bit configuration registers over three wires: an active-low select, a serial clock that idles low, and one half-duplex data line. The data line appears at the block boundary as a separate input, an output and an output enable, so that the pad that joins them is left to the chip top. Every register is visible at all times on a flat parallel bus, from which the rest of the chip takes its settings.

Each access is a 24-bit frame. It holds an 8-bit header and then 16 data bits, all sent most significant bit first. The header gives the direction, then a 2-bit slave identifier, then a 5-bit register index. Only frames that carry identifier `01` are acted on, so up to three further slaves can share the select line. A write is stored only when select is released after a complete frame. A complete access of either kind to register 0 returns the whole bank to its reset image. The select, clock and data inputs are brought into the system clock domain through two-flop synchronizers, and their edges are detected in that domain.

Top module: `regmap_serial_slave`

## Requirements
- R1: While `res_n` is low, and on the cycles after it rises, register i on `regs_flat[16*i +: 16]` holds ((i * 16'h0101) XOR 16'h5A00) truncated to 16 bits, and `sdio_oe` is 0.
- R2: A frame is, in order: a direction bit (0 = write, 1 = read), two identifier bits, five register-index bits and sixteen data bits. Each field is sent MSB first, and each bit is taken on a rising `sclk` while `sel_n` is low.
- R3: A write with identifier 01 to a non-zero index updates only that register, and only after `sel_n` rises following the 24th rising `sclk`. No register changes while `sel_n` is low.
- R4: A frame whose identifier is not 01 changes no register, and the slave never asserts `sdio_oe` during it.
- R5: In a read with identifier 01, each of the 16 rising `sclk` edges after the header drives the next register bit, MSB first, with `sdio_oe` high. The slave drops `sdio_oe` after the following falling `sclk`, so a host that samples at the falling edge receives the register value.
- R6: A complete frame with identifier 01 and index 0, whether read or write, restores every register to its R1 value once `sel_n` rises. The write data is discarded.
- R7: A frame closed by `sel_n` before its 24th rising `sclk` changes no register.
- R8: Releasing `sel_n` clears the bit position, so the next frame starts at the direction bit. `sclk` activity while `sel_n` is high neither drives the line nor changes a register.
- R9: A frame is opened only by a high-to-low transition of `sel_n` seen after reset. If `sel_n` is already low when `res_n` rises, the clocks that follow are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all serial inputs |
| res_n | input | 1 | Asynchronous active-low reset; loads the register image |
| sel_n | input | 1 | Active-low slave select |
| sclk | input | 1 | Serial clock, idle low, return-to-zero pulses |
| sdio_in | input | 1 | Data line as seen from the pad |
| sdio_out | output | 1 | Read data toward the pad, 0 when not driving |
| sdio_oe | output | 1 | Pad drive enable for the data line |
| regs_flat | output | 512 | All registers; register i at bits 16*i+15 down to 16*i |

## Verification
The bench aims at the places where a timing or decoding slip is easy to hide. A write that is committed early would show a changed register while select is still low. A frame that is too short must leave the bank alone, or a design that commits on any release would store garbage. Accesses to register 0 in both directions must restore the full image; a design that only zeroes register 0 or ignores reads would fail here. A foreign identifier must leave the line undriven. Select held low across reset release, and clocks toggled with select high, check that a design neither treats a level as a start nor drives the line outside a frame.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

    parameter int REG_COUNT = 32;
    parameter int REG_W     = 16;
    parameter int ID_W      = 2;

    // Reset image: register i = (i * 0x0101) ^ 0x5A00
    function automatic logic [REG_COUNT*REG_W-1:0] default_image();
        logic [REG_COUNT*REG_W-1:0] img;
        img = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            img[i*REG_W +: REG_W] = REG_W'((i * 32'h0101) ^ 32'h5A00);
        end
        return img;
    endfunction

endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
    parameter int           N    = 3,
    parameter logic [N-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         res_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic stage1_q, stage2_q;
        always_ff @(posedge clk or negedge res_n) begin
            if (!res_n) begin
                stage1_q <= INIT[g];
                stage2_q <= INIT[g];
            end else begin
                stage1_q <= d[g];
                stage2_q <= stage1_q;
            end
        end
        assign q[g] = stage2_q;
    end

endmodule

// File: rtl/frame_engine.sv
module frame_engine #(
    parameter int            AW     = 5,
    parameter int            DW     = 16,
    parameter int            IDW    = 2,
    parameter logic [IDW-1:0] DEV_ID = 2'b01
) (
    input  logic          clk,
    input  logic          res_n,
    input  logic          sel_lvl,
    input  logic          sclk_lvl,
    input  logic          sdi_lvl,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] reg_addr,
    output logic          wr_stb,
    output logic [DW-1:0] wr_data,
    output logic          clr_stb,
    output logic          sdo,
    output logic          sdo_oe,
    output logic          sel_rise,
    output logic          sclk_fall,
    output logic          hit,
    output logic [$clog2(1+IDW+AW+DW+1)-1:0] bit_pos
);

    localparam int HB    = 1 + IDW + AW;
    localparam int FRAME = HB + DW;
    localparam int CW    = $clog2(FRAME + 1);
    localparam int IW    = $clog2(DW);

    typedef struct packed {
        logic          sel_p;
        logic          sclk_p;
        logic          active;
        logic [CW-1:0] cnt;
        logic [HB-1:0] hdr;
        logic [DW-1:0] data;
        logic          oe;
        logic          dout;
        logic          wr;
        logic          clr;
    } eng_t;

    eng_t st_d, st_q;

    logic           sel_fall, sclk_rise, is_read;
    logic [CW-1:0]  off;
    logic [IW-1:0]  idx;

    always_comb begin
        sel_rise  = sel_lvl & ~st_q.sel_p;
        sel_fall  = ~sel_lvl & st_q.sel_p;
        sclk_rise = sclk_lvl & ~st_q.sclk_p;
        sclk_fall = ~sclk_lvl & st_q.sclk_p;
        is_read   = st_q.hdr[HB-1];
        hit       = (st_q.cnt >= CW'(HB)) && (st_q.hdr[HB-2 -: IDW] == DEV_ID);
        off       = st_q.cnt - CW'(HB);
        idx       = IW'(DW - 1) - off[IW-1:0];

        st_d        = st_q;
        st_d.sel_p  = sel_lvl;
        st_d.sclk_p = sclk_lvl;
        st_d.wr     = 1'b0;
        st_d.clr    = 1'b0;

        if (sel_rise) begin
            if (st_q.active && st_q.cnt == CW'(FRAME) && hit) begin
                if (st_q.hdr[AW-1:0] == '0) st_d.clr = 1'b1;
                else if (!is_read)          st_d.wr  = 1'b1;
            end
            st_d.active = 1'b0;
            st_d.cnt    = '0;
            st_d.oe     = 1'b0;
        end else if (sel_fall) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.hdr    = '0;
            st_d.oe     = 1'b0;
        end else if (st_q.active) begin
            if (sclk_rise && st_q.cnt < CW'(FRAME)) begin
                if (st_q.cnt < CW'(HB)) begin
                    st_d.hdr = {st_q.hdr[HB-2:0], sdi_lvl};
                end else if (!is_read) begin
                    st_d.data = {st_q.data[DW-2:0], sdi_lvl};
                end else if (hit) begin
                    st_d.oe   = 1'b1;
                    st_d.dout = rd_data[idx];
                end
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (sclk_fall) begin
                st_d.oe = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge res_n) begin
        if (!res_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_addr = st_q.hdr[AW-1:0];
    assign wr_stb   = st_q.wr;
    assign wr_data  = st_q.data;
    assign clr_stb  = st_q.clr;
    assign sdo      = st_q.dout & st_q.oe;
    assign sdo_oe   = st_q.oe;
    assign bit_pos  = st_q.cnt;

endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
    parameter int                     NREG = 32,
    parameter int                     DW   = 16,
    parameter logic [NREG*DW-1:0]     INIT = '0,
    localparam int                    AW   = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               res_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic               clr,
    input  logic [AW-1:0]      rd_addr,
    output logic [DW-1:0]      rd_data,
    output logic [NREG*DW-1:0] image
);

    logic [NREG-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (clr)        mem_d = INIT;
        else if (wr_en) mem_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge res_n) begin
        if (!res_n) mem_q <= INIT;
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_addr];
    assign image   = mem_q;

endmodule

// File: rtl/regmap_serial_slave.sv
module regmap_serial_slave #(
    parameter int                 NREG        = regmap_pkg::REG_COUNT,
    parameter int                 DW          = regmap_pkg::REG_W,
    parameter logic [1:0]         DEV_ID      = 2'b01,
    parameter logic [NREG*DW-1:0] RESET_IMAGE = regmap_pkg::default_image()
) (
    input  logic               clk,
    input  logic               res_n,
    input  logic               sel_n,
    input  logic               sclk,
    input  logic               sdio_in,
    output logic               sdio_out,
    output logic               sdio_oe,
    output logic [NREG*DW-1:0] regs_flat
);

    localparam int AW    = $clog2(NREG);
    localparam int IDW   = regmap_pkg::ID_W;
    localparam int FRAME = 1 + IDW + AW + DW;
    localparam int CW    = $clog2(FRAME + 1);

    logic [2:0]    sync_q;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] rd_data, wr_data;
    logic          wr_stb, clr_stb;
    logic          eng_sel_rise, eng_sclk_fall, eng_hit;
    logic [CW-1:0] eng_pos;

    // Select resets to its asserted level so a select held low through reset opens no frame.
    sync_bank #(.N(3), .INIT(3'b000)) u_sync (
        .clk   (clk),
        .res_n (res_n),
        .d     ({sel_n, sclk, sdio_in}),
        .q     (sync_q)
    );

    frame_engine #(.AW(AW), .DW(DW), .IDW(IDW), .DEV_ID(DEV_ID)) u_engine (
        .clk       (clk),
        .res_n     (res_n),
        .sel_lvl   (sync_q[2]),
        .sclk_lvl  (sync_q[1]),
        .sdi_lvl   (sync_q[0]),
        .rd_data   (rd_data),
        .reg_addr  (reg_addr),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .clr_stb   (clr_stb),
        .sdo       (sdio_out),
        .sdo_oe    (sdio_oe),
        .sel_rise  (eng_sel_rise),
        .sclk_fall (eng_sclk_fall),
        .hit       (eng_hit),
        .bit_pos   (eng_pos)
    );

    reg_bank #(.NREG(NREG), .DW(DW), .INIT(RESET_IMAGE)) u_bank (
        .clk     (clk),
        .res_n   (res_n),
        .wr_en   (wr_stb),
        .wr_addr (reg_addr),
        .wr_data (wr_data),
        .clr     (clr_stb),
        .rd_addr (reg_addr),
        .rd_data (rd_data),
        .image   (regs_flat)
    );

endmodule

// File: rtl/regmap_serial_slave_checker.sv
module regmap_serial_slave_checker #(
    parameter int W     = 512,
    parameter int CW    = 5,
    parameter int FRAME = 24
) (
    input logic          clk,
    input logic          res_n,
    input logic          sdio_oe,
    input logic          sdio_out,
    input logic [W-1:0]  regs_flat,
    input logic          end_evt,
    input logic          fall_evt,
    input logic          hit,
    input logic [CW-1:0] pos
);

    // R3: the bank moves only in the two cycles that follow a select release
    a_r3_bank_quiet: assert property (@(posedge clk) disable iff (!res_n)
        !$past(end_evt) |=> $stable(regs_flat));

    // R5: a falling serial clock releases the line
    a_r5_release_on_fall: assert property (@(posedge clk) disable iff (!res_n)
        fall_evt |=> !sdio_oe);

    // R5: a driven bit holds steady while the line stays enabled
    a_r5_bit_steady: assert property (@(posedge clk) disable iff (!res_n)
        (sdio_oe && $past(sdio_oe)) |-> $stable(sdio_out));

    // R4: the line is driven only for frames carrying this slave's identifier
    a_r4_foreign_silent: assert property (@(posedge clk) disable iff (!res_n)
        sdio_oe |-> hit);

    // R7: the bit position never passes the frame length
    a_r7_pos_bound: assert property (@(posedge clk) disable iff (!res_n)
        pos <= CW'(FRAME));

endmodule

bind regmap_serial_slave regmap_serial_slave_checker #(
    .W(NREG*DW), .CW(CW), .FRAME(FRAME)
) u_checker (
    .clk       (clk),
    .res_n     (res_n),
    .sdio_oe   (sdio_oe),
    .sdio_out  (sdio_out),
    .regs_flat (regs_flat),
    .end_evt   (eng_sel_rise),
    .fall_evt  (eng_sclk_fall),
    .hit       (eng_hit),
    .pos       (eng_pos)
);

// File: tb/test_regmap_serial_slave.sv
`timescale 1ns/1ps
module test_regmap_serial_slave;

    localparam int HALF = 8;

    logic clk = 1'b0;
    logic res_n = 1'b0;
    logic sel_n = 1'b1;
    logic sclk = 1'b0;
    logic sdio_in = 1'b0;
    logic sdio_out, sdio_oe;
    logic [511:0] regs_flat;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 0;
    bit  oe_seen = 0;

    always #5 clk = ~clk;

    regmap_serial_slave i_regmap_serial_slave (
        .clk       (clk),
        .res_n     (res_n),
        .sel_n     (sel_n),
        .sclk      (sclk),
        .sdio_in   (sdio_in),
        .sdio_out  (sdio_out),
        .sdio_oe   (sdio_oe),
        .regs_flat (regs_flat)
    );

    function automatic logic [15:0] dflt(int i);
        return 16'((i * 32'h0101) ^ 32'h5A00);
    endfunction

    function automatic logic [15:0] reg_at(int i);
        return regs_flat[i*16 +: 16];
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model, updated each clock ----------------
    logic [15:0] m_regs [32];
    bit [2:0] h_sel, h_clk, h_dat;
    bit       m_active, m_oe, m_dout;
    int       m_cnt;
    bit [7:0] m_hdr;
    bit [15:0] m_data;
    bit       p_wr, p_clr;
    int       p_addr;
    bit [15:0] p_data;

    always @(posedge clk or negedge res_n) begin
        if (!res_n) begin
            for (int i = 0; i < 32; i++) m_regs[i] = dflt(i);
            h_sel = '0; h_clk = '0; h_dat = '0;
            m_active = 0; m_oe = 0; m_dout = 0; m_cnt = 0;
            m_hdr = '0; m_data = '0; p_wr = 0; p_clr = 0;
        end else begin
            bit sn, so, cn, co, dn, nw, nc;
            int na;
            bit [15:0] nd;
            sn = h_sel[1]; so = h_sel[2];
            cn = h_clk[1]; co = h_clk[2];
            dn = h_dat[1];
            nw = 0; nc = 0; na = 0; nd = '0;
            if (sn && !so) begin
                if (m_active && m_cnt == 24 && m_hdr[6:5] == 2'b01) begin
                    if (m_hdr[4:0] == 0) nc = 1;
                    else if (!m_hdr[7]) begin nw = 1; na = m_hdr[4:0]; nd = m_data; end
                end
                m_active = 0; m_cnt = 0; m_oe = 0;
            end else if (!sn && so) begin
                m_active = 1; m_cnt = 0; m_hdr = '0; m_oe = 0;
            end else if (m_active) begin
                if (cn && !co && m_cnt < 24) begin
                    if (m_cnt < 8) m_hdr = {m_hdr[6:0], dn};
                    else if (!m_hdr[7]) m_data = {m_data[14:0], dn};
                    else if (m_hdr[6:5] == 2'b01) begin
                        m_oe = 1;
                        m_dout = m_regs[m_hdr[4:0]][15 - (m_cnt - 8)];
                    end
                    m_cnt++;
                end else if (!cn && co) begin
                    m_oe = 0;
                end
            end
            if (p_clr) for (int i = 0; i < 32; i++) m_regs[i] = dflt(i);
            else if (p_wr) m_regs[p_addr] = p_data;
            p_wr = nw; p_clr = nc; p_addr = na; p_data = nd;
            h_sel = {h_sel[1:0], sel_n};
            h_clk = {h_clk[1:0], sclk};
            h_dat = {h_dat[1:0], sdio_in};
        end
    end

    always @(negedge clk) begin
        if (sdio_oe) oe_seen = 1;
        if (res_n && !done) begin
            chk("R5", "line enable vs model", {31'b0, sdio_oe}, {31'b0, m_oe});
            chk("R5", "line data vs model", {31'b0, sdio_out}, {31'b0, m_oe & m_dout});
            for (int i = 0; i < 32; i++) begin
                if (reg_at(i) !== m_regs[i])
                    chk("R3", $sformatf("reg %0d vs model", i), {16'b0, reg_at(i)}, {16'b0, m_regs[i]});
            end
        end
    end

    // ---------------- host side ----------------
    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input bit rw, input bit [1:0] dev, input bit [4:0] addr,
                        input bit [15:0] data, input int nbits, input bit open_sel,
                        input bit close_sel, output bit [15:0] rdata);
        bit [23:0] frame;
        frame = {rw, dev, addr, (rw ? 16'h0000 : data)};
        rdata = '0;
        oe_seen = 0;
        @(negedge clk);
        if (open_sel) sel_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdio_in = frame[23 - i];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            if (i >= 8) rdata = {rdata[14:0], sdio_out};
            sclk = 1'b0;
        end
        wait_clk(HALF);
        if (close_sel) begin
            sel_n = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        res_n = 1'b0;
        wait_clk(4);
        res_n = 1'b1;
        wait_clk(4);
    endtask

    task automatic chk_defaults(string req);
        for (int i = 0; i < 32; i++)
            chk(req, $sformatf("default reg %0d", i), {16'b0, reg_at(i)}, {16'b0, dflt(i)});
    endtask

    initial begin
        bit [15:0] rd;
        wait_clk(3);
        // R1: image under reset and after release
        chk("R1", "reg 7 during reset", {16'b0, reg_at(7)}, {16'b0, dflt(7)});
        res_n = 1'b1;
        wait_clk(4);
        chk_defaults("R1");
        chk("R1", "line idle", {31'b0, sdio_oe}, 32'd0);

        // R3: write stays pending while select is low, lands on release
        xfer(0, 2'b01, 5'd5, 16'hBEEF, 24, 1, 0, rd);
        wait_clk(6);
        chk("R3", "reg 5 before release", {16'b0, reg_at(5)}, {16'b0, dflt(5)});
        sel_n = 1'b1;
        wait_clk(HALF);
        chk("R3", "reg 5 after release", {16'b0, reg_at(5)}, 32'hBEEF);
        chk("R3", "reg 6 untouched", {16'b0, reg_at(6)}, {16'b0, dflt(6)});

        // R2: field order, another index and pattern
        xfer(0, 2'b01, 5'd30, 16'h8001, 24, 1, 1, rd);
        chk("R2", "reg 30 written", {16'b0, reg_at(30)}, 32'h8001);

        // R5: read back MSB first
        xfer(1, 2'b01, 5'd5, 16'h0, 24, 1, 1, rd);
        chk("R5", "read reg 5", {16'b0, rd}, 32'hBEEF);
        xfer(1, 2'b01, 5'd17, 16'h0, 24, 1, 1, rd);
        chk("R5", "read reg 17", {16'b0, rd}, {16'b0, dflt(17)});
        chk("R5", "line released after read", {31'b0, sdio_oe}, 32'd0);

        // R4: foreign identifiers
        xfer(0, 2'b10, 5'd7, 16'h1234, 24, 1, 1, rd);
        chk("R4", "reg 7 after foreign write", {16'b0, reg_at(7)}, {16'b0, dflt(7)});
        xfer(1, 2'b11, 5'd5, 16'h0, 24, 1, 1, rd);
        chk("R4", "no drive on foreign read", {31'b0, oe_seen}, 32'd0);
        xfer(0, 2'b00, 5'd5, 16'h0000, 24, 1, 1, rd);
        chk("R4", "reg 5 after foreign id 00", {16'b0, reg_at(5)}, 32'hBEEF);

        // R7: short frame discarded; R8: next frame starts fresh
        xfer(0, 2'b01, 5'd9, 16'hFFFF, 23, 1, 1, rd);
        chk("R7", "reg 9 after 23-bit frame", {16'b0, reg_at(9)}, {16'b0, dflt(9)});
        xfer(0, 2'b01, 5'd9, 16'hFFFF, 12, 1, 1, rd);
        chk("R7", "reg 9 after 12-bit frame", {16'b0, reg_at(9)}, {16'b0, dflt(9)});
        xfer(0, 2'b01, 5'd9, 16'h1234, 24, 1, 1, rd);
        chk("R8", "reg 9 after full frame", {16'b0, reg_at(9)}, 32'h1234);

        // R8: clocks with select high
        oe_seen = 0;
        for (int i = 0; i < 30; i++) begin
            sdio_in = i[0];
            wait_clk(HALF); sclk = 1'b1;
            wait_clk(HALF); sclk = 1'b0;
        end
        wait_clk(HALF);
        chk("R8", "no drive while deselected", {31'b0, oe_seen}, 32'd0);
        chk("R8", "reg 9 kept", {16'b0, reg_at(9)}, 32'h1234);

        // R6: read of register 0 restores the image
        xfer(0, 2'b01, 5'd3, 16'h0F0F, 24, 1, 1, rd);
        chk("R3", "reg 3 written", {16'b0, reg_at(3)}, 32'h0F0F);
        xfer(1, 2'b01, 5'd0, 16'h0, 24, 1, 1, rd);
        chk("R6", "read reg 0 data", {16'b0, rd}, {16'b0, dflt(0)});
        chk_defaults("R6");

        // R6: write to register 0 restores the image and drops its data
        xfer(0, 2'b01, 5'd2, 16'hC0DE, 24, 1, 1, rd);
        xfer(0, 2'b01, 5'd0, 16'h1111, 24, 1, 1, rd);
        chk("R6", "reg 0 after write 0", {16'b0, reg_at(0)}, {16'b0, dflt(0)});
        chk("R6", "reg 2 after write 0", {16'b0, reg_at(2)}, {16'b0, dflt(2)});

        // R1: reset input after changes
        xfer(0, 2'b01, 5'd31, 16'h7777, 24, 1, 1, rd);
        chk("R2", "reg 31 written", {16'b0, reg_at(31)}, 32'h7777);
        do_reset();
        chk_defaults("R1");

        // R9: select already low at reset release
        @(negedge clk);
        res_n = 1'b0;
        sel_n = 1'b0;
        wait_clk(4);
        res_n = 1'b1;
        wait_clk(4);
        xfer(0, 2'b01, 5'd4, 16'hAAAA, 24, 0, 1, rd);
        chk("R9", "reg 4 after level start", {16'b0, reg_at(4)}, {16'b0, dflt(4)});
        xfer(0, 2'b01, 5'd4, 16'hAAAA, 24, 1, 1, rd);
        chk("R9", "reg 4 after proper start", {16'b0, reg_at(4)}, 32'hAAAA);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule